// File: doc/BRIEF.md
# Standby-Aware Transmit Pad Controller

This block decides, on every clock, how two transmit pads are driven. One pad is dedicated to the infrared transmit stream. The other pad is shared between a serial transmit stream and a general-purpose output. Each pad is described by a drive-enable and a data bit. A pad is driven low, driven from its selected source, or released (drive-enable low) so that the board can hold the net.

Two kinds of power-on reset reach the block. The standby-supply POR clears everything. The main-supply "power good" level marks whether the main domain is alive. While main power is absent, and for a few clocks after it returns, the main-domain configuration is held at its reset value. No pad follows a data stream during that time.

A single standby-domain bit, the release bit, survives loss of main power. While it is set, it forces the shared pad to tristate, whatever the function select or the activate bit says. Only a standby POR clears it. Software changes it through a write strobe, which counts only while the main domain is out of reset.

Top module: `txpad_pwr_ctrl`

## Requirements
- R1: While `sby_por_n_i` is low, and on the first sample after it rises, both pads drive low (`*_oe_o`=1, `*_dat_o`=0), and the release bit is clear.
- R2: The infrared pad drives low until the activate bit is set. It then drives the value `ir_tx_i` had one clock earlier. A change of the activate bit appears at the pad after two clocks.
- R3: With the shared pad in its serial function, the pad drives low while the activate bit is clear. Once the bit is set, the pad drives the value `ser_tx_i` had one clock earlier.
- R4: With the shared pad in its general-purpose function, the pad drives `gpio_dat_i` XOR `gpio_pol_i`. It is therefore low until exactly one of the two bits is set.
- R5: While the release bit is set, the shared pad has `sh_oe_o`=0. This holds whatever the function select, the activate bit or main power are. The pad is driven again on the clock after the bit is cleared.
- R6: The release bit keeps its value while `main_pwr_ok_i` is low. Only a standby POR clears it.
- R7: While `main_pwr_ok_i` is low, and for SYNC_STAGES clocks after it rises, both pads drive low unless R5 applies. Configuration inputs are ignored during that time.
- R8: The infrared pad ignores the release bit. Its `ir_oe_o` stays 1 at all times.
- R9: A write of the release bit (`rel_wr_en_i`=1 with value `rel_wr_val_i`) takes effect on the next clock, and only while the main domain is out of reset. Writes made during main power loss are dropped.
- R10: Function select encoding: `sh_fn_sel_i`=0 selects the general-purpose output, and 1 selects the serial transmit stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Standby-domain clock |
| sby_por_n_i | input | 1 | Standby-supply power-on reset, active low, asynchronous |
| main_pwr_ok_i | input | 1 | Main supply present; low holds the main domain in reset |
| active_i | input | 1 | Serial port activate bit |
| sh_fn_sel_i | input | 1 | Shared pad function: 0 general-purpose, 1 serial |
| gpio_dat_i | input | 1 | General-purpose data bit |
| gpio_pol_i | input | 1 | General-purpose polarity bit |
| rel_wr_en_i | input | 1 | Write strobe for the release bit |
| rel_wr_val_i | input | 1 | Value written to the release bit |
| ir_tx_i | input | 1 | Infrared transmit stream |
| ser_tx_i | input | 1 | Serial transmit stream |
| ir_oe_o | output | 1 | Infrared pad drive enable |
| ir_dat_o | output | 1 | Infrared pad data |
| sh_oe_o | output | 1 | Shared pad drive enable (0 = tristate) |
| sh_dat_o | output | 1 | Shared pad data |

## Verification
Both transmit streams are toggled with the activate bit clear and then set. This separates a pad that is properly gated low from one that leaks its stream. All four combinations of the data and polarity bits are applied, which tells an XOR apart from an OR or a plain pass-through. The release bit is driven across main power loss, attempted writes during the loss, and a standby POR. These cases expose a bit that is kept in the wrong domain, or one that is cleared by the wrong reset. A long run of random configurations with random power drops is then compared every clock against a behavioural model.

// File: rtl/txpad_pkg.sv
package txpad_pkg;

  typedef enum logic {
    FN_GPIO   = 1'b0,
    FN_SERIAL = 1'b1
  } pad_fn_e;

  typedef struct packed {
    logic    active;
    pad_fn_e fn;
    logic    gdat;
    logic    gpol;
  } main_cfg_t;

  typedef struct packed {
    logic oe;
    logic dat;
  } pad_drive_t;

  // level driven by a general-purpose pin
  function automatic logic gpio_level(input logic dat, input logic pol);
    return dat ^ pol;
  endfunction

  // level of a stream gated by activation and main-domain health
  function automatic logic stream_level(input logic main_ok, input logic active,
                                        input logic stream);
    return main_ok & active & stream;
  endfunction

  // shared pad source selection
  function automatic logic shared_level(input logic main_ok, input main_cfg_t cfg,
                                        input logic stream);
    if (cfg.fn == FN_SERIAL) return stream_level(main_ok, cfg.active, stream);
    return main_ok & gpio_level(cfg.gdat, cfg.gpol);
  endfunction

endpackage

// File: rtl/txpad_main_sync.sv
module txpad_main_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic sby_por_n_i,
  input  logic main_pwr_ok_i,
  output logic main_ok_o
);
  localparam int MSB = STAGES - 1;

  logic             arst_n;
  logic [MSB:0]     chain_q;

  assign arst_n = sby_por_n_i & main_pwr_ok_i;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge arst_n) begin
        if (!arst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= 1'b1;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign main_ok_o = chain_q[MSB];

  initial begin
    assert (STAGES >= 2) else $error("STAGES must be at least 2");
  end

  // power loss is seen as main-domain reset on the following clock
  assert_main_drop_R7: assert property (@(posedge clk_i) disable iff (!sby_por_n_i)
    !main_pwr_ok_i |=> !main_ok_o);

endmodule

// File: rtl/txpad_main_cfg.sv
module txpad_main_cfg
  import txpad_pkg::*;
(
  input  logic      clk_i,
  input  logic      sby_por_n_i,
  input  logic      main_ok_i,
  input  main_cfg_t cfg_i,
  output main_cfg_t cfg_o
);
  main_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge sby_por_n_i) begin
    if (!sby_por_n_i)   cfg_q <= '0;
    else if (main_ok_i) cfg_q <= cfg_i;
    else                cfg_q <= '0;
  end

  assign cfg_o = cfg_q;

  // configuration is held at reset while the main domain is down
  assert_cfg_held_R7: assert property (@(posedge clk_i) disable iff (!sby_por_n_i)
    !main_ok_i |=> (cfg_o == '0));

endmodule

// File: rtl/txpad_sby_release.sv
module txpad_sby_release (
  input  logic clk_i,
  input  logic sby_por_n_i,
  input  logic main_ok_i,
  input  logic wr_en_i,
  input  logic wr_val_i,
  output logic release_o
);
  logic rel_q;
  logic wr_accept;

  assign wr_accept = wr_en_i & main_ok_i;

  always_ff @(posedge clk_i or negedge sby_por_n_i) begin
    if (!sby_por_n_i)   rel_q <= 1'b0;
    else if (wr_accept) rel_q <= wr_val_i;
  end

  assign release_o = rel_q;

  assert_write_dropped_R9: assert property (@(posedge clk_i) disable iff (!sby_por_n_i)
    !main_ok_i |=> $stable(release_o));

  assert_write_lands_R9: assert property (@(posedge clk_i) disable iff (!sby_por_n_i)
    (wr_en_i && main_ok_i) |=> (release_o == $past(wr_val_i)));

endmodule

// File: rtl/txpad_pad_reg.sv
module txpad_pad_reg
  import txpad_pkg::*;
(
  input  logic       clk_i,
  input  logic       sby_por_n_i,
  input  logic       release_i,
  input  logic       level_i,
  output pad_drive_t drive_o
);
  pad_drive_t drv_q;

  always_ff @(posedge clk_i or negedge sby_por_n_i) begin
    if (!sby_por_n_i) begin
      drv_q.oe  <= 1'b1;
      drv_q.dat <= 1'b0;
    end else begin
      drv_q.oe  <= ~release_i;
      drv_q.dat <= level_i & ~release_i;
    end
  end

  assign drive_o = drv_q;

  assert_release_tristate_R5: assert property (@(posedge clk_i) disable iff (!sby_por_n_i)
    release_i |=> !drive_o.oe);

  assert_drive_back_R5: assert property (@(posedge clk_i) disable iff (!sby_por_n_i)
    !release_i |=> drive_o.oe);

endmodule

// File: rtl/txpad_pwr_ctrl.sv
module txpad_pwr_ctrl
  import txpad_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic sby_por_n_i,
  input  logic main_pwr_ok_i,
  input  logic active_i,
  input  logic sh_fn_sel_i,
  input  logic gpio_dat_i,
  input  logic gpio_pol_i,
  input  logic rel_wr_en_i,
  input  logic rel_wr_val_i,
  input  logic ir_tx_i,
  input  logic ser_tx_i,
  output logic ir_oe_o,
  output logic ir_dat_o,
  output logic sh_oe_o,
  output logic sh_dat_o
);
  logic       main_ok;
  logic       release_bit;
  main_cfg_t  cfg_in;
  main_cfg_t  cfg_q;
  logic       ir_level;
  logic       sh_level;
  pad_drive_t ir_drv;
  pad_drive_t sh_drv;

  txpad_main_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i         (clk_i),
    .sby_por_n_i   (sby_por_n_i),
    .main_pwr_ok_i (main_pwr_ok_i),
    .main_ok_o     (main_ok)
  );

  assign cfg_in.active = active_i;
  assign cfg_in.fn     = pad_fn_e'(sh_fn_sel_i);
  assign cfg_in.gdat   = gpio_dat_i;
  assign cfg_in.gpol   = gpio_pol_i;

  txpad_main_cfg u_cfg (
    .clk_i       (clk_i),
    .sby_por_n_i (sby_por_n_i),
    .main_ok_i   (main_ok),
    .cfg_i       (cfg_in),
    .cfg_o       (cfg_q)
  );

  txpad_sby_release u_rel (
    .clk_i       (clk_i),
    .sby_por_n_i (sby_por_n_i),
    .main_ok_i   (main_ok),
    .wr_en_i     (rel_wr_en_i),
    .wr_val_i    (rel_wr_val_i),
    .release_o   (release_bit)
  );

  assign ir_level = stream_level(main_ok, cfg_q.active, ir_tx_i);
  assign sh_level = shared_level(main_ok, cfg_q, ser_tx_i);

  txpad_pad_reg u_ir_pad (
    .clk_i       (clk_i),
    .sby_por_n_i (sby_por_n_i),
    .release_i   (1'b0),
    .level_i     (ir_level),
    .drive_o     (ir_drv)
  );

  txpad_pad_reg u_sh_pad (
    .clk_i       (clk_i),
    .sby_por_n_i (sby_por_n_i),
    .release_i   (release_bit),
    .level_i     (sh_level),
    .drive_o     (sh_drv)
  );

  assign ir_oe_o  = ir_drv.oe;
  assign ir_dat_o = ir_drv.dat;
  assign sh_oe_o  = sh_drv.oe;
  assign sh_dat_o = sh_drv.dat;

  assert_ir_ignores_release_R8: assert property (@(posedge clk_i) disable iff (!sby_por_n_i)
    release_bit |=> ir_oe_o);

  assert_release_sticky_R6: assert property (@(posedge clk_i) disable iff (!sby_por_n_i)
    (release_bit && !rel_wr_en_i) |=> release_bit);

  assert_low_in_main_reset_R7: assert property (@(posedge clk_i) disable iff (!sby_por_n_i)
    (!main_ok && !release_bit) |=> (sh_oe_o && !sh_dat_o && !ir_dat_o));

  assert_inactive_serial_low_R3: assert property (@(posedge clk_i) disable iff (!sby_por_n_i)
    (cfg_q.fn == FN_SERIAL && !cfg_q.active) |=> !sh_dat_o);

endmodule

// File: tb/sim_txpad_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_txpad_pwr_ctrl;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic sby_por_n = 1'b0, pwr_ok = 1'b0, active = 1'b0, fn_sel = 1'b0;
  logic gdat = 1'b0, gpol = 1'b0, wr_en = 1'b0, wr_val = 1'b0, ir_tx = 1'b0, ser_tx = 1'b0;
  logic ir_oe, ir_dat, sh_oe, sh_dat;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  txpad_pwr_ctrl #(.SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk), .sby_por_n_i(sby_por_n), .main_pwr_ok_i(pwr_ok),
    .active_i(active), .sh_fn_sel_i(fn_sel), .gpio_dat_i(gdat), .gpio_pol_i(gpol),
    .rel_wr_en_i(wr_en), .rel_wr_val_i(wr_val), .ir_tx_i(ir_tx), .ser_tx_i(ser_tx),
    .ir_oe_o(ir_oe), .ir_dat_o(ir_dat), .sh_oe_o(sh_oe), .sh_dat_o(sh_dat)
  );

  // behavioural model state
  int m_up;          // clocks seen with main power present
  bit m_act, m_fn, m_gd, m_gp, m_rel;
  bit e_ir_oe, e_ir_dat, e_sh_oe, e_sh_dat;

  task automatic model_step();
    bit ok;
    if (!sby_por_n) begin
      m_up = 0; m_act = 0; m_fn = 0; m_gd = 0; m_gp = 0; m_rel = 0;
      e_ir_oe = 1; e_ir_dat = 0; e_sh_oe = 1; e_sh_dat = 0;
      return;
    end
    if (!pwr_ok) m_up = 0;
    ok = (m_up >= SYNC);
    e_ir_oe  = 1;
    e_ir_dat = ok && m_act && ir_tx;
    e_sh_oe  = !m_rel;
    if (m_rel)     e_sh_dat = 0;
    else if (m_fn) e_sh_dat = ok && m_act && ser_tx;
    else           e_sh_dat = ok && (m_gd != m_gp);
    if (wr_en && ok) m_rel = wr_val;
    if (ok) begin m_act = active; m_fn = fn_sel; m_gd = gdat; m_gp = gpol; end
    else    begin m_act = 0; m_fn = 0; m_gd = 0; m_gp = 0; end
    if (pwr_ok && m_up < SYNC) m_up++;
  endtask

  function automatic string sh_tag();
    if (!e_sh_oe)       return "R5";
    if (m_up < SYNC)    return "R7";
    if (m_fn)           return "R3";
    return "R4";
  endfunction

  // compare against the model on every clock, 1 ns after the edge
  always @(posedge clk) begin
    model_step();
    #1;
    tests++;
    if (ir_oe !== e_ir_oe || ir_dat !== e_ir_dat) begin
      fails++;
      $display("FAIL %s ir pad: got oe=%b dat=%b expected oe=%b dat=%b",
               (m_up < SYNC) ? "R7" : "R2", ir_oe, ir_dat, e_ir_oe, e_ir_dat);
    end
    tests++;
    if (sh_oe !== e_sh_oe || (e_sh_oe && sh_dat !== e_sh_dat)) begin
      fails++;
      $display("FAIL %s shared pad: got oe=%b dat=%b expected oe=%b dat=%b",
               sh_tag(), sh_oe, sh_dat, e_sh_oe, e_sh_dat);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic write_rel(input logic v);
    wr_en = 1; wr_val = v; tick(1); wr_en = 0; wr_val = 0;
  endtask

  initial begin
    tick(3);
    sby_por_n = 1;
    tick(1);
    check("R1", "ir_oe after standby POR", ir_oe, 1'b1);
    check("R1", "ir_dat after standby POR", ir_dat, 1'b0);
    check("R1", "sh_oe after standby POR", sh_oe, 1'b1);
    check("R1", "sh_dat after standby POR", sh_dat, 1'b0);
    // configuration ignored while main power is absent
    active = 1; fn_sel = 1; ser_tx = 1; ir_tx = 1; tick(4);
    check("R7", "ir_dat with main off", ir_dat, 1'b0);
    check("R7", "sh_dat with main off", sh_dat, 1'b0);
    active = 0;
    pwr_ok = 1; tick(SYNC + 3);
    check("R3", "serial pad while inactive", sh_dat, 1'b0);
    check("R2", "ir pad while inactive", ir_dat, 1'b0);
    active = 1; tick(3);
    check("R3", "serial pad follows stream", sh_dat, 1'b1);
    check("R2", "ir pad follows stream", ir_dat, 1'b1);
    for (int i = 0; i < 24; i++) begin
      ser_tx = i[0]; ir_tx = i[1] ^ i[0]; tick(1);
    end
    ser_tx = 0; ir_tx = 0; tick(2);
    check("R3", "serial pad stream low", sh_dat, 1'b0);
    // general-purpose function, all four combinations
    fn_sel = 0; ser_tx = 1;
    for (int c = 0; c < 4; c++) begin
      gdat = c[0]; gpol = c[1]; tick(3);
      check("R4", $sformatf("gpio dat=%0d pol=%0d", c[0], c[1]), sh_dat, c[0] ^ c[1]);
    end
    gdat = 0; gpol = 0; tick(3);
    check("R10", "select 0 ignores serial stream", sh_dat, 1'b0);
    fn_sel = 1; tick(3);
    check("R10", "select 1 picks serial stream", sh_dat, 1'b1);
    // release bit
    write_rel(1); tick(1);
    check("R5", "released pad", sh_oe, 1'b0);
    check("R8", "ir pad still driven", ir_oe, 1'b1);
    fn_sel = 0; active = 0; gdat = 1; tick(3);
    check("R5", "release beats function select", sh_oe, 1'b0);
    pwr_ok = 0; tick(5);
    check("R6", "release kept with main off", sh_oe, 1'b0);
    check("R7", "ir low with main off", ir_dat, 1'b0);
    write_rel(0); tick(1);
    check("R9", "write dropped during main loss", sh_oe, 1'b0);
    pwr_ok = 1; tick(SYNC + 2);
    check("R6", "release kept after main return", sh_oe, 1'b0);
    write_rel(0); tick(1);
    check("R5", "pad driven after clear", sh_oe, 1'b1);
    write_rel(1); tick(2);
    sby_por_n = 0; tick(2); sby_por_n = 1; tick(1);
    check("R6", "standby POR clears release", sh_oe, 1'b1);
    check("R1", "sh_dat after second POR", sh_dat, 1'b0);
    pwr_ok = 0; tick(1); write_rel(1); pwr_ok = 1; tick(SYNC + 3);
    check("R9", "write in main reset dropped", sh_oe, 1'b1);
    // random run with power drops, compared by the model every clock
    for (int i = 0; i < 600; i++) begin
      active = $urandom_range(0, 1); fn_sel = $urandom_range(0, 1);
      gdat = $urandom_range(0, 1); gpol = $urandom_range(0, 1);
      ir_tx = $urandom_range(0, 1); ser_tx = $urandom_range(0, 1);
      wr_en = ($urandom_range(0, 9) == 0); wr_val = $urandom_range(0, 1);
      pwr_ok = ($urandom_range(0, 19) != 0);
      sby_por_n = ($urandom_range(0, 99) != 0);
      tick(1);
    end
    wr_en = 0; sby_por_n = 1; pwr_ok = 1;
    tick(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule